// File: doc/BRIEF.md
# Countdown Divider with Shared Rate Selector

This block is the timebase of a real-time clock. It receives a clock-enable that pulses at 32.768 kHz and uses it to step a 15-stage binary divider. A 3-bit control pattern sets the divider to one of three states: counting, held cleared, or frozen because the oscillator is off. A 4-bit rate code picks one divider tap through a 16-way selector in which code 0 means "no tap". That one selection drives two outputs. The first is a square-wave pin, gated by an enable bit. The second is a single-cycle periodic event for an interrupt controller, raised each time the chosen tap rises.

The bit order of the control pattern is significant. In this document `osc_mode[2]` corresponds to the most significant bit of the field. The divider counts up from zero. Divider bit k therefore carries a square wave of 32768 / 2^(k+1) Hz.

Top module: `rtc_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, the divider is cleared. `sqw_out` and `rate_evt` are low after that edge.
- R2: With `osc_mode` = 3'b010 the divider advances by one on each clock edge where `tick_en` is 1. On edges where `tick_en` is 0 it keeps its value.
- R3: With `osc_mode[2:1]` = 2'b11 the divider is cleared on every edge, whatever `tick_en` does. The registered square-wave level is also cleared and no event is raised. Counting then resumes from zero.
- R4: Any other `osc_mode` value freezes the divider and the registered square-wave level. No event is raised.
- R5: `rate_sel` codes select the following taps. Code 1 is bit 6 (256 Hz) and code 2 is bit 7 (128 Hz). Codes 3..15 are bit (code−2), which gives 32768 >> (code−1) Hz. The range is 8192 Hz (bit 1) down to 2 Hz (bit 13).
- R6: `rate_sel` = 0 selects no tap. The square-wave level goes low on the next tick and no periodic event occurs.
- R7: `rate_evt` is high for exactly the one clock after a counting tick on which the selected divider bit goes from 0 to 1.
- R8: `sqw_out` equals the registered selected-tap level while `sqw_en` is 1. It is 0 whenever `sqw_en` is 0.
- R9: A change of `rate_sel` does not disturb the divider. It reaches the square-wave level and the event logic only on the next counting tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 32.768 kHz clock-enable pulse |
| osc_mode | input | 3 | Oscillator/divider control pattern |
| rate_sel | input | 4 | Tap selection code |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_out | output | 1 | Gated square wave at the selected rate |
| rate_evt | output | 1 | One-cycle pulse on each rising edge of the selected tap |

## Verification
The slowest tap, 2 Hz, rises only after 8192 counting ticks. A rate change that lands between ticks leaves the square-wave level stale until the next tick. Both conditions are rare under purely random input. The stimulus therefore includes long directed runs with `tick_en` held high on the top codes, and it interleaves hold and freeze windows at arbitrary phases of the divider. Random segments change `rate_sel` and `sqw_en` while `tick_en` is sparse, so many selection changes arrive between ticks. A bench model counts ticks since the last clear and compares the outputs on every cycle.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;
  localparam int DIV_STAGES = 15;
  localparam int RATE_W     = 4;
  localparam int RATE_CODES = 1 << RATE_W;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_HOLD = 2'd2
  } div_mode_e;

  // Decode of the 3-bit control pattern: 11x holds, 010 runs, rest off.
  function automatic div_mode_e decode_mode(input logic [2:0] pat);
    if (pat[2:1] == 2'b11)   return MODE_HOLD;
    else if (pat == 3'b010)  return MODE_RUN;
    else                     return MODE_OFF;
  endfunction

  // Divider bit driven by a non-zero rate code.
  function automatic int tap_bit(input int code);
    if (code == 1)      return 6;
    else if (code == 2) return 7;
    else                return code - 2;
  endfunction
endpackage

// File: rtl/rtc_mode_decode.sv
module rtc_mode_decode
  import rtc_div_pkg::*;
(
  input  logic [2:0] osc_mode,
  input  logic       tick_en,
  output div_mode_e  mode,
  output logic       hold,
  output logic       advance
);
  always_comb begin
    mode    = decode_mode(osc_mode);
    hold    = (mode == MODE_HOLD);
    advance = (mode == MODE_RUN) && tick_en;
  end
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_div_pkg::*;
#(
  parameter int STAGES = DIV_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              advance,
  input  logic              tick_en,
  input  div_mode_e         mode,
  output logic [STAGES-1:0] count,
  output logic [STAGES-1:0] count_nxt
);
  assign count_nxt = count + {{(STAGES-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n || hold) count <= '0;
    else if (advance)   count <= count_nxt;
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> count == '0);
  p_hold_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> count == '0);
  p_off_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> $stable(count));
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && !tick_en) |=> $stable(count));
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && tick_en) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/rtc_tap_select.sv
module rtc_tap_select
  import rtc_div_pkg::*;
#(
  parameter int STAGES = DIV_STAGES,
  parameter int SEL_W  = RATE_W
) (
  input  logic [STAGES-1:0] count,
  input  logic [SEL_W-1:0]  sel,
  output logic              tap
);
  localparam int N_CODES = 1 << SEL_W;
  logic [N_CODES-1:0] taps;

  assign taps[0] = 1'b0;
  for (genvar c = 1; c < N_CODES; c++) begin : g_tap
    localparam int B = tap_bit(c);
    if (B < STAGES) begin : g_in
      assign taps[c] = count[B];
    end else begin : g_none
      assign taps[c] = 1'b0;
    end
  end

  assign tap = taps[sel];
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider
  import rtc_div_pkg::*;
#(
  parameter int STAGES = DIV_STAGES,
  parameter int SEL_W  = RATE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [2:0]       osc_mode,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             sqw_en,
  output logic             sqw_out,
  output logic             rate_evt
);
  div_mode_e         mode;
  logic              hold, advance;
  logic [STAGES-1:0] count, count_nxt;
  logic              tap_now, tap_nxt, tap_rise;
  logic              sqw_lvl;

  rtc_mode_decode u_mode (
    .osc_mode (osc_mode),
    .tick_en  (tick_en),
    .mode     (mode),
    .hold     (hold),
    .advance  (advance)
  );

  rtc_div_chain #(.STAGES(STAGES)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .advance   (advance),
    .tick_en   (tick_en),
    .mode      (mode),
    .count     (count),
    .count_nxt (count_nxt)
  );

  rtc_tap_select #(.STAGES(STAGES), .SEL_W(SEL_W)) u_sel_now (
    .count (count),
    .sel   (rate_sel),
    .tap   (tap_now)
  );

  rtc_tap_select #(.STAGES(STAGES), .SEL_W(SEL_W)) u_sel_nxt (
    .count (count_nxt),
    .sel   (rate_sel),
    .tap   (tap_nxt)
  );

  assign tap_rise = tap_nxt & ~tap_now;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      sqw_lvl  <= 1'b0;
      rate_evt <= 1'b0;
    end else begin
      rate_evt <= advance & tap_rise;
      if (advance) sqw_lvl <= tap_nxt;
    end
  end

  assign sqw_out = sqw_en & sqw_lvl;

  p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rate_evt |=> !rate_evt);
  p_evt_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> !rate_evt);
  p_code0_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0) |=> !rate_evt);
  p_lvl_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !hold) |=> $stable(sqw_lvl));
  p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!rate_evt && !sqw_out));
endmodule

// File: tb/sim_rtc_divider.sv
module sim_rtc_divider;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [2:0] osc_mode = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0;
  logic       sqw_out, rate_evt;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  // model state
  int  m_n = 0;
  bit  m_lvl = 1'b0, m_evt = 1'b0;
  string evt_tag = "R1", lvl_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_divider u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .osc_mode(osc_mode),
    .rate_sel(rate_sel), .sqw_en(sqw_en), .sqw_out(sqw_out), .rate_evt(rate_evt)
  );

  function automatic int code_freq(input int code);
    if (code == 1) return 256;
    if (code == 2) return 128;
    return 32768 >> (code - 1);
  endfunction

  function automatic int half_period(input int code);
    return 16384 / code_freq(code);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", tag, what, act, exp, cycles);
    end
  endtask

  // One cycle: check outputs, drive new inputs, advance model as the edge will.
  task automatic step(input logic [2:0] oc, input logic [3:0] rs, input logic en, input logic tk);
    int h;
    @(negedge clk);
    cycles++;
    check(rate_evt, m_evt, evt_tag, "rate_evt");
    check(sqw_out, sqw_en & m_lvl, sqw_en ? lvl_tag : "R8", "sqw_out");
    osc_mode = oc; rate_sel = rs; sqw_en = en; tick_en = tk;
    if (oc[2:1] == 2'b11) begin
      m_n = 0; m_lvl = 0; m_evt = 0; evt_tag = "R3"; lvl_tag = "R3";
    end else if (oc == 3'b010 && tk) begin
      m_n = (m_n + 1) % 32768;
      if (rs == 0) begin
        m_lvl = 0; m_evt = 0; evt_tag = "R6"; lvl_tag = "R6";
      end else begin
        h = half_period(rs);
        m_lvl = ((m_n / h) % 2) == 1;
        m_evt = (m_n % (2 * h)) == h;
        evt_tag = "R7"; lvl_tag = "R5";
      end
    end else begin
      m_evt = 0;
      evt_tag = (oc == 3'b010) ? "R2" : "R4";
      lvl_tag = "R9";
    end
  endtask

  task automatic run(input int n, input logic [2:0] oc, input logic [3:0] rs,
                     input logic en, input int tick_pct);
    for (int i = 0; i < n; i++)
      step(oc, rs, en, ($urandom % 100) < tick_pct);
  endtask

  function automatic logic [2:0] off_pattern(input int k);
    case (k % 5)
      0: return 3'b000; 1: return 3'b001; 2: return 3'b011;
      3: return 3'b100; default: return 3'b101;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_2885));
    // R1: reset dominates even with run pattern and ticks
    osc_mode = 3'b010; tick_en = 1'b1; rate_sel = 4'd3; sqw_en = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(sqw_out, 1'b0, "R1", "sqw_out after reset");
    check(rate_evt, 1'b0, "R1", "rate_evt after reset");
    tick_en = 1'b0;
    m_n = 0; m_lvl = 0; m_evt = 0;

    // R2/R5/R7: fastest rate, ticks every cycle then sparse
    run(64, 3'b010, 4'd3, 1'b1, 100);
    run(200, 3'b010, 4'd3, 1'b1, 30);
    // R5: codes 1 and 2 (256/128 Hz)
    run(600, 3'b010, 4'd1, 1'b1, 100);
    run(600, 3'b010, 4'd2, 1'b1, 100);
    // R3: hold mid-phase, both hold patterns, then restart from zero
    run(20, 3'b110, 4'd2, 1'b1, 100);
    run(20, 3'b111, 4'd3, 1'b1, 50);
    run(40, 3'b010, 4'd3, 1'b1, 100);
    // R4: every off pattern freezes the divider and level
    for (int k = 0; k < 5; k++) begin
      run(30, off_pattern(k), 4'd4, 1'b1, 100);
      run(25, 3'b010, 4'd4, 1'b1, 100);
    end
    // R6: code 0 never produces a level or an event
    run(300, 3'b010, 4'd0, 1'b1, 100);
    // R8: disabled output stays low while divider runs
    run(300, 3'b010, 4'd5, 1'b0, 100);
    // R9: change rate between ticks, level stays stale until next tick
    step(3'b010, 4'd3, 1'b1, 1'b1);
    step(3'b010, 4'd3, 1'b1, 1'b1);
    step(3'b010, 4'd9, 1'b1, 1'b0);
    step(3'b010, 4'd3, 1'b1, 1'b0);
    step(3'b010, 4'd4, 1'b1, 1'b1);
    // R5: slowest rate, full 2 Hz periods
    run(18000, 3'b010, 4'd15, 1'b1, 100);

    // constrained random segments
    for (int seg = 0; seg < 120; seg++) begin
      int r = $urandom % 10;
      logic [2:0] oc = (r < 7) ? 3'b010 : (r < 8) ? {2'b11, 1'($urandom)}
                                          : off_pattern($urandom);
      run(20 + ($urandom % 300), oc, 4'($urandom), 1'($urandom % 4 != 0),
          ((seg % 2) == 0) ? 100 : 20);
    end

    step(3'b000, 4'd0, 1'b0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule